// File: doc/BRIEF.md
# Big-Endian Load/Store Alignment Unit

This block sits between a 64-bit integer datapath and a byte-addressed data memory that is 64 bits wide. It forms the effective address as a base register value plus a sign-extended 16-bit displacement. It checks that the access is naturally aligned for its size. For stores it builds the byte-lane enables and the lane-placed write data. For loads it picks the addressed lanes out of the returned doubleword and widens them to a full register, with either sign or zero fill.

Lanes follow big-endian order. Byte offset 0 within a doubleword is the most significant byte of the memory word. A misaligned address raises a fault flag and blocks the memory access. A load that targets register index 0 completes without asserting the register write enable.

The memory has one cycle of read latency. The widened load result and its strobe are registered one cycle after the memory data arrives. They therefore appear two clock edges after the request cycle.

Top module: `be_lsu_align`

## Requirements
- R1: `mem_addr` equals `req_base` plus `req_disp` sign-extended to 64 bits, with modulo-2^64 wrap.
- R2: `req_size` encodes the width: 0 = byte, 1 = half word, 2 = word, 3 = double word. `align_fault` is high for a valid request whose address bits [2:0] have a 1 in any position below bit `req_size`.
- R3: A faulting request asserts neither `mem_we` nor `mem_re`, drives `mem_be` to all zeros, and leaves memory contents unchanged.
- R4: For an aligned store of 2^size bytes at offset k, `mem_be` has exactly the bits for offsets k to k+2^size-1 set. Bit 7 stands for offset 0 and bit 0 for offset 7.
- R5: Store data is the low 8·2^size bits of `req_wsrc`. Its most significant byte goes to offset k, and offset k+m lies on `mem_wdata[63-8(k+m) -: 8]`.
- R6: A load at offset k takes its first (most significant) byte from `mem_rdata[63-8k -: 8]` and continues through higher offsets in order.
- R7: With `req_unsigned` = 0, byte, half-word and word loads copy the loaded value's top bit into all upper result bits.
- R8: With `req_unsigned` = 1, narrower loads fill the upper result bits with zeros. A double-word load ignores `req_unsigned`.
- R9: `mem_re` is high in the request cycle. `ld_valid` with `ld_data` and `ld_rd` follows two clock edges later, and back-to-back loads are accepted every cycle.
- R10: `ld_we` equals `ld_valid` unless `ld_rd` is 0, in which case `ld_we` stays low while `ld_data` is still delivered.
- R11: After reset, `ld_valid` and `ld_we` are low until a load completes.
- R12: `mem_re` is high only for a valid aligned load, and `mem_we` only for a valid aligned store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request present |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access width code (0 byte, 1 half, 2 word, 3 double) |
| req_unsigned | input | 1 | Zero-fill narrow loads |
| req_base | input | 64 | Base register value |
| req_disp | input | 16 | Signed displacement |
| req_rd | input | 5 | Load destination register index |
| req_wsrc | input | 64 | Store source register value |
| mem_addr | output | 64 | Effective byte address |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_be | output | 8 | Byte-lane write enables, bit 7 = offset 0 |
| mem_wdata | output | 64 | Lane-placed store data |
| mem_rdata | input | 64 | Doubleword returned one cycle after `mem_re` |
| align_fault | output | 1 | Misaligned access flag |
| ld_valid | output | 1 | Load result strobe |
| ld_we | output | 1 | Register write enable for the load result |
| ld_rd | output | 5 | Destination index of the load result |
| ld_data | output | 64 | Extended load result |

## Verification
The bench builds the block with its default parameters: 64-bit data, 64-bit addresses, a 16-bit displacement and 5-bit register indices. These values make every offset of every access size reachable within one doubleword. They also make the sign-extension boundaries meaningful at bit 7, bit 15, bit 31 and the full width. A displacement of 16 bits lets negative offsets wrap a base near the top of the 64-bit space. A 5-bit index lets a register counter pass through index 0 during the load sweep.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_HALF  = 2'd1,
      SZ_WORD  = 2'd2,
      SZ_DWORD = 2'd3
   } acc_size_e;

   localparam int NUM_SIZES = 4;

endpackage

// File: rtl/lsu_ea_adder.sv
module lsu_ea_adder #(
   parameter int ADDR_W = 64,
   parameter int DISP_W = 16
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [DISP_W-1:0] disp,
   output logic [ADDR_W-1:0] ea
);

   generate
      if (DISP_W == ADDR_W) begin : g_full_disp
         assign ea = base + disp;
      end else begin : g_sext_disp
         logic [ADDR_W-1:0] disp_x;
         assign disp_x = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
         assign ea     = base + disp_x;
      end
   endgenerate

endmodule

// File: rtl/lsu_align_check.sv
module lsu_align_check
   import lsu_align_pkg::*;
#(
   parameter int OFF_W = 3
) (
   input  acc_size_e        size,
   input  logic [OFF_W-1:0] off,
   output logic [OFF_W-1:0] size_mask,
   output logic             misaligned
);

   always_comb begin
      for (int b = 0; b < OFF_W; b++) begin
         size_mask[b] = (b < int'(size));
      end
   end

   assign misaligned = |(off & size_mask);

endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane #(
   parameter int DATA_W = 64,
   localparam int LANES = DATA_W / 8,
   localparam int OFF_W = $clog2(LANES)
) (
   input  logic              en,
   input  logic [OFF_W-1:0]  off,
   input  logic [OFF_W-1:0]  size_mask,
   input  logic [DATA_W-1:0] src,
   output logic [LANES-1:0]  be,
   output logic [DATA_W-1:0] wdata
);

   logic [OFF_W-1:0] last_off;
   logic [OFF_W-1:0] lsh_bytes;

   assign last_off  = off | size_mask;
   // lowest source byte lands on the lane of the last offset
   assign lsh_bytes = ~last_off;
   assign wdata     = src << {lsh_bytes, 3'b000};

   generate
      for (genvar j = 0; j < LANES; j++) begin : g_lane
         localparam logic [OFF_W-1:0] LANE_OFF = OFF_W'(LANES - 1 - j);
         assign be[j] = en && (LANE_OFF >= off) && (LANE_OFF <= last_off);
      end
   endgenerate

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
   import lsu_align_pkg::*;
#(
   parameter int DATA_W = 64,
   localparam int LANES = DATA_W / 8,
   localparam int OFF_W = $clog2(LANES)
) (
   input  logic [DATA_W-1:0] rdata,
   input  acc_size_e         size,
   input  logic [OFF_W-1:0]  off,
   input  logic              uns,
   output logic [DATA_W-1:0] data
);

   logic [OFF_W-1:0]  size_mask;
   logic [OFF_W-1:0]  last_off;
   logic [DATA_W-1:0] shifted;
   logic [DATA_W-1:0] ext [NUM_SIZES];

   always_comb begin
      for (int b = 0; b < OFF_W; b++) begin
         size_mask[b] = (b < int'(size));
      end
   end

   assign last_off = off | size_mask;
   assign shifted  = rdata >> {~last_off, 3'b000};

   generate
      for (genvar s = 0; s < NUM_SIZES; s++) begin : g_width
         localparam int NB = 8 << s;
         if (NB >= DATA_W) begin : g_full
            assign ext[s] = shifted;
         end else begin : g_narrow
            logic fill;
            assign fill   = !uns && shifted[NB-1];
            assign ext[s] = {{(DATA_W-NB){fill}}, shifted[NB-1:0]};
         end
      end
   endgenerate

   assign data = ext[size];

endmodule

// File: rtl/be_lsu_align.sv
module be_lsu_align
   import lsu_align_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int ADDR_W = 64,
   parameter int DISP_W = 16,
   parameter int RIDX_W = 5,
   localparam int LANES = DATA_W / 8,
   localparam int OFF_W = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_store,
   input  logic [1:0]        req_size,
   input  logic              req_unsigned,
   input  logic [ADDR_W-1:0] req_base,
   input  logic [DISP_W-1:0] req_disp,
   input  logic [RIDX_W-1:0] req_rd,
   input  logic [DATA_W-1:0] req_wsrc,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_re,
   output logic              mem_we,
   output logic [LANES-1:0]  mem_be,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              align_fault,
   output logic              ld_valid,
   output logic              ld_we,
   output logic [RIDX_W-1:0] ld_rd,
   output logic [DATA_W-1:0] ld_data
);

   generate
      if (DATA_W < 64 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data_w
         $error("DATA_W must be a power of two of at least 64");
      end
      if (DISP_W < 1 || DISP_W > ADDR_W) begin : g_bad_disp_w
         $error("DISP_W must lie between 1 and ADDR_W");
      end
      if (ADDR_W < OFF_W) begin : g_bad_addr_w
         $error("ADDR_W must cover the lane offset");
      end
      if (RIDX_W < 1) begin : g_bad_ridx_w
         $error("RIDX_W must be at least 1");
      end
   endgenerate

   acc_size_e        size_in;
   logic [OFF_W-1:0] off_in;
   logic [OFF_W-1:0] size_mask;
   logic             misaligned;
   logic             store_ok;
   logic             load_ok;

   assign size_in = acc_size_e'(req_size);
   assign off_in  = mem_addr[OFF_W-1:0];

   lsu_ea_adder #(
      .ADDR_W (ADDR_W),
      .DISP_W (DISP_W)
   ) u_ea (
      .base (req_base),
      .disp (req_disp),
      .ea   (mem_addr)
   );

   lsu_align_check #(
      .OFF_W (OFF_W)
   ) u_chk (
      .size       (size_in),
      .off        (off_in),
      .size_mask  (size_mask),
      .misaligned (misaligned)
   );

   assign align_fault = req_valid && misaligned;
   assign store_ok    = req_valid && req_store && !misaligned;
   assign load_ok     = req_valid && !req_store && !misaligned;
   assign mem_we      = store_ok;
   assign mem_re      = load_ok;

   lsu_store_lane #(
      .DATA_W (DATA_W)
   ) u_st (
      .en        (store_ok),
      .off       (off_in),
      .size_mask (size_mask),
      .src       (req_wsrc),
      .be        (mem_be),
      .wdata     (mem_wdata)
   );

   // load context, held while the memory returns data
   logic              ctx_v;
   acc_size_e         ctx_size;
   logic              ctx_uns;
   logic [OFF_W-1:0]  ctx_off;
   logic [RIDX_W-1:0] ctx_rd;
   logic [DATA_W-1:0] ext_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctx_v    <= 1'b0;
         ctx_size <= SZ_BYTE;
         ctx_uns  <= 1'b0;
         ctx_off  <= '0;
         ctx_rd   <= '0;
      end else begin
         ctx_v <= load_ok;
         if (load_ok) begin
            ctx_size <= size_in;
            ctx_uns  <= req_unsigned;
            ctx_off  <= off_in;
            ctx_rd   <= req_rd;
         end
      end
   end

   lsu_load_extract #(
      .DATA_W (DATA_W)
   ) u_ld (
      .rdata (mem_rdata),
      .size  (ctx_size),
      .off   (ctx_off),
      .uns   (ctx_uns),
      .data  (ext_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ld_valid <= 1'b0;
         ld_we    <= 1'b0;
         ld_rd    <= '0;
         ld_data  <= '0;
      end else begin
         ld_valid <= ctx_v;
         ld_we    <= ctx_v && (ctx_rd != '0);
         if (ctx_v) begin
            ld_rd   <= ctx_rd;
            ld_data <= ext_data;
         end
      end
   end

   AST_FAULT_BLOCKS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      align_fault |-> (!mem_we && !mem_re && mem_be == '0)); // R3

   AST_BE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> ($countones(mem_be) == (32'd1 << req_size))); // R4

   AST_LOAD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |-> ##2 ld_valid); // R9

   AST_NO_SPURIOUS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid |-> $past(mem_re, 2)); // R9

   AST_NO_R0_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ld_we |-> (ld_valid && ld_rd != '0)); // R10

   AST_EXCLUSIVE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re)); // R12

endmodule

// File: tb/be_lsu_align_test.sv
`timescale 1ns/1ps
module be_lsu_align_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_store, req_unsigned;
   logic [1:0]  req_size;
   logic [63:0] req_base, req_wsrc;
   logic [15:0] req_disp;
   logic [4:0]  req_rd;
   logic [63:0] mem_addr, mem_wdata, mem_rdata, ld_data;
   logic        mem_re, mem_we, align_fault, ld_valid, ld_we;
   logic [7:0]  mem_be;
   logic [4:0]  ld_rd;

   int n_cmp = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   be_lsu_align uut (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_store (req_store), .req_size (req_size),
      .req_unsigned (req_unsigned), .req_base (req_base), .req_disp (req_disp),
      .req_rd (req_rd), .req_wsrc (req_wsrc),
      .mem_addr (mem_addr), .mem_re (mem_re), .mem_we (mem_we), .mem_be (mem_be),
      .mem_wdata (mem_wdata), .mem_rdata (mem_rdata), .align_fault (align_fault),
      .ld_valid (ld_valid), .ld_we (ld_we), .ld_rd (ld_rd), .ld_data (ld_data)
   );

   // behavioural byte memory, big-endian doubleword read, one cycle latency
   logic [7:0] mem_b [64];
   always @(posedge clk) begin
      if (mem_re) begin
         for (int i = 0; i < 8; i++)
            mem_rdata[63-8*i -: 8] <= mem_b[int'({mem_addr[5:3], 3'b000}) + i];
      end
   end

   // expected load pipeline
   bit          p1_v, p2_v;
   logic [4:0]  p1_rd, p2_rd;
   logic [63:0] p1_d, p2_d;
   string       p1_tag, p2_tag;

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_ld();
      chk("R9 ld_valid", 64'(ld_valid), 64'(p2_v));
      chk("R10 ld_we", 64'(ld_we), 64'(p2_v && p2_rd != 5'd0));
      if (p2_v) begin
         chk("R9 ld_rd", 64'(ld_rd), 64'(p2_rd));
         chk(p2_tag, ld_data, p2_d);
      end
   endtask

   task automatic issue(input bit v, input bit st, input int sz, input bit un,
                        input logic [63:0] base, input logic [15:0] disp,
                        input logic [4:0] rd, input logic [63:0] src);
      logic [63:0] ea, wd, bmask, val;
      logic [7:0]  be;
      int          n, k;
      bit          fault, exp_re, exp_we;
      string       tag;
      req_valid = v; req_store = st; req_size = 2'(sz); req_unsigned = un;
      req_base = base; req_disp = disp; req_rd = rd; req_wsrc = src;
      #1;
      ea     = base + {{48{disp[15]}}, disp};
      n      = 1 << sz;
      k      = int'(ea[2:0]);
      fault  = v && ((k % n) != 0);
      exp_re = v && !st && !fault;
      exp_we = v && st && !fault;
      be = '0; wd = '0; bmask = '0;
      if (exp_we) begin
         for (int m = 0; m < n; m++) begin
            be[7-(k+m)] = 1'b1;
            bmask[(7-(k+m))*8 +: 8] = 8'hFF;
            wd[(7-(k+m))*8 +: 8] = src[(n-1-m)*8 +: 8];
         end
      end
      if (v) chk("R1 mem_addr", mem_addr, ea);
      chk("R2 align_fault", 64'(align_fault), 64'(fault));
      chk("R12 mem_re", 64'(mem_re), 64'(exp_re));
      chk("R12 mem_we", 64'(mem_we), 64'(exp_we));
      chk(fault ? "R3 mem_be" : "R4 mem_be", 64'(mem_be), 64'(be));
      if (exp_we) chk("R5 mem_wdata", mem_wdata & bmask, wd);
      val = '0;
      if (exp_re) begin
         for (int m = 0; m < n; m++)
            val = (val << 8) | 64'(mem_b[int'(ea[5:0]) + m]);
         if (!un && n < 8 && val[8*n-1]) val = val | ~((64'd1 << (8*n)) - 64'd1);
      end
      tag = (n == 8) ? "R6 ld_data" : (un ? "R8 ld_data" : "R7 ld_data");
      @(posedge clk);
      if (exp_we) begin
         for (int m = 0; m < n; m++)
            mem_b[int'(ea[5:0]) + m] = src[(n-1-m)*8 +: 8];
      end
      p2_v = p1_v; p2_rd = p1_rd; p2_d = p1_d; p2_tag = p1_tag;
      p1_v = exp_re; p1_rd = rd; p1_d = val; p1_tag = tag;
      @(negedge clk);
      check_ld();
   endtask

   task automatic idle();
      issue(1'b0, 1'b0, 0, 1'b0, 64'd0, 16'd0, 5'd0, 64'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL R9 watchdog expired actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin
      logic [63:0] tgt, base;
      logic [15:0] disp;
      int          rdc;
      p1_v = 0; p2_v = 0; p1_rd = '0; p2_rd = '0; p1_d = '0; p2_d = '0;
      p1_tag = "R6 ld_data"; p2_tag = "R6 ld_data";
      for (int i = 0; i < 64; i++) mem_b[i] = 8'(i * 37 + 11);
      rst_n = 1'b0;
      req_valid = 0; req_store = 0; req_size = 0; req_unsigned = 0;
      req_base = '0; req_disp = '0; req_rd = '0; req_wsrc = '0;
      repeat (3) @(negedge clk);
      chk("R11 ld_valid", 64'(ld_valid), 64'd0);
      chk("R11 ld_we", 64'(ld_we), 64'd0);
      rst_n = 1'b1;
      idle();

      // double-word stores, negative displacement
      for (int i = 0; i < 8; i++)
         issue(1'b1, 1'b1, 3, 1'b0, 64'h1010 + 64'(i * 8), 16'hFFF0, 5'd0,
               64'hF0E1_D2C3_B4A5_9687 + 64'(i) * 64'h1111_1111_1111_1111);
      // narrower stores at several offsets, absolute (base 0) and indirect (disp 0)
      issue(1'b1, 1'b1, 2, 1'b0, 64'd0, 16'd8,  5'd0, 64'hDEAD_BEEF_8123_4567);
      issue(1'b1, 1'b1, 2, 1'b0, 64'd12, 16'd0, 5'd0, 64'h0000_0000_7ACE_0FF1);
      issue(1'b1, 1'b1, 1, 1'b0, 64'd18, 16'd0, 5'd0, 64'h1234_5678_9ABC_80F7);
      issue(1'b1, 1'b1, 1, 1'b0, 64'd0, 16'd22, 5'd0, 64'hFFFF_FFFF_FFFF_0155);
      issue(1'b1, 1'b1, 0, 1'b0, 64'd27, 16'd0, 5'd0, 64'h0102_0304_0506_07A9);
      issue(1'b1, 1'b1, 0, 1'b0, 64'd31, 16'd0, 5'd0, 64'h0000_0000_0000_0042);
      // misaligned stores: no write
      issue(1'b1, 1'b1, 1, 1'b0, 64'd33, 16'd0, 5'd0, 64'hAAAA_AAAA_AAAA_AAAA);
      issue(1'b1, 1'b1, 2, 1'b0, 64'd42, 16'd0, 5'd0, 64'hBBBB_BBBB_BBBB_BBBB);
      issue(1'b1, 1'b1, 3, 1'b0, 64'd52, 16'd0, 5'd0, 64'hCCCC_CCCC_CCCC_CCCC);
      // read back bytes around the rejected stores (R3)
      issue(1'b1, 1'b0, 0, 1'b1, 64'd33, 16'd0, 5'd3, 64'd0);
      issue(1'b1, 1'b0, 2, 1'b1, 64'd40, 16'd0, 5'd4, 64'd0);
      issue(1'b1, 1'b0, 3, 1'b0, 64'd48, 16'd0, 5'd5, 64'd0);

      // load sweep: every size, every aligned offset, signed and unsigned,
      // base near the top of the address space with wrapping displacement
      rdc = 0;
      for (int sz = 0; sz < 4; sz++) begin
         for (int un = 0; un < 2; un++) begin
            for (int off = 0; off < 8; off += (1 << sz)) begin
               tgt  = 64'hFFFF_FFFF_FFFF_FFC0 | 64'(((sz * 2 + un + off) % 8) * 8 + off);
               disp = (sz % 2 == 0) ? 16'h0100 : 16'hFF00;
               base = tgt - {{48{disp[15]}}, disp};
               issue(1'b1, 1'b0, sz, un[0], base, disp, 5'(rdc), 64'd0);
               rdc++;
            end
         end
      end

      // misaligned loads
      issue(1'b1, 1'b0, 1, 1'b0, 64'd1, 16'd0, 5'd7, 64'd0);
      issue(1'b1, 1'b0, 2, 1'b0, 64'd6, 16'd0, 5'd7, 64'd0);
      issue(1'b1, 1'b0, 3, 1'b0, 64'd4, 16'd0, 5'd7, 64'd0);
      issue(1'b1, 1'b0, 3, 1'b0, 64'd15, 16'd0, 5'd7, 64'd0);
      // load to register 0 between ordinary loads
      issue(1'b1, 1'b0, 0, 1'b0, 64'd8, 16'd0, 5'd0, 64'd0);
      issue(1'b1, 1'b0, 1, 1'b1, 64'd22, 16'd0, 5'd31, 64'd0);
      issue(1'b1, 1'b0, 2, 1'b0, 64'd0, 16'd0, 5'd0, 64'd0);
      repeat (3) idle();

      summary();
      $finish;
   end

endmodule